// File: doc/BRIEF.md
# Three-Channel Keypad LED PWM Sequencer

This block turns a small set of control fields into on/off enables for three keypad LED channels. A free-running frame counter, advanced by a time-base tick, defines a fixed PWM frame (64 ticks by default; at 0.78125 µs per tick that is a 50 µs frame, a 20 kHz rate). Within a frame the block either lights every enabled channel together for a brightness-dependent duty (shared mode) or hands out consecutive time slots to the channels according to a balance code (sliced mode). A brightness code on a logarithmic scale shortens the on-time in both modes.

An external PWM pin can be routed into any channel. A routed channel follows the pin directly when the internal PWM is off, or passes the internal waveform only while the pin is high when it is on. All control fields are captured only at the end of a frame, so a change never produces a truncated or stretched pulse. The outputs are registered and feed the analog sink drivers, which are outside this block.

Top module: `keyLedSeq`

## Requirements
- R1: While `rstN` is low, `ledOn` is 3'b000, the frame position returns to 0 and the captured settings clear to all zeros, so outputs stay off until the first frame end after reset.
- R2: The frame position advances by one only in cycles with `tick` high and wraps from `FRAME_TICKS-1` to 0; `ledOn` is registered, so its value after a clock edge reflects the position, settings and pin present at that edge.
- R3: All control inputs except `extPwm` are captured only on the tick that wraps the position to 0; changing them at any other time has no effect on `ledOn` before that tick.
- R4: With the captured `keyEn` low, all three outputs are off.
- R5: With `keyEn` high and `intPwmEn` low, each `ledOn[i]` equals `chanEn[i]`; `balance`, `bright` and `overlap` have no effect.
- R6: The brightness code gives an on-length of 0 ticks for code 0 and floor(L / 2^(7-code)) ticks for codes 1 to 7, where L is the full-frame length of the waveform being scaled (1/64, 1/32, ... 1/2, 1 of it).
- R7: With `keyEn`, `intPwmEn` and `overlap` high, every enabled channel is on at positions below floor(FRAME_TICKS / 2^(7-bright)) (code 0: never) and off elsewhere; `balance` has no effect.
- R8: With `keyEn` and `intPwmEn` high and `overlap` low, channel 0, then 1, then 2 take consecutive slots starting at position 0; the full share per balance code (channel 0/1/2) is 0: F/0/0, 1: 0/F/0, 2: 0/0/F, 3: F/2,F/2,0, 4: 0,F/2,F/2, 5: F/2,0,F/2, 6: F/3 each, 7: F/2,F/4,F/4 (F = FRAME_TICKS, divisions rounded down), each share is scaled as in R6, and the rest of the frame is off; a channel is lit in its slot only when its `chanEn` bit is high.
- R9: When captured `pinEn` and `extSel[i]` are high, `ledOn[i]` is further gated by `extPwm` (active high), sampled live every cycle: in R5 mode the output is `chanEn[i] & extPwm`, in R7/R8 mode it is the internal waveform AND `extPwm`.
- R10: With captured `pinEn` low, `extSel` and `extPwm` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base strobe, advances the frame position |
| keyEn | input | 1 | Global enable for all three channels |
| intPwmEn | input | 1 | Use the internal PWM waveform (else direct on/off) |
| pinEn | input | 1 | Enable the external PWM pin function |
| overlap | input | 1 | 1 = shared duty, 0 = sequential slots |
| chanEn | input | 3 | Per-channel enable |
| extSel | input | 3 | Per-channel external PWM routing |
| balance | input | 3 | Slot share code for sliced mode |
| bright | input | 3 | Logarithmic brightness code |
| extPwm | input | 1 | External PWM pin, active high |
| ledOn | output | 3 | Registered channel enables |

## Verification
The assertions assume only that `rstN` is asserted before the first edge and that `FRAME_TICKS` is at least 4; they allow any pattern of `tick` and any control value in any cycle, since the block is meant to tolerate mid-frame writes. The stimulus therefore changes control fields at arbitrary points in a frame, gaps the tick randomly and toggles the external pin freely, so the properties on latching, exclusivity of slots and global disable are exercised under all orderings rather than under a convenient one.

// File: rtl/keyPwmPkg.sv
package keyPwmPkg;

  typedef struct packed {
    logic advance;   // position moves this cycle
    logic boundary;  // last tick of the frame: wrap and capture settings
  } frameStrobeT;

  typedef struct packed {
    logic       keyEn;
    logic       intPwmEn;
    logic       pinEn;
    logic       overlap;
    logic [2:0] chanEn;
    logic [2:0] extSel;
    logic [2:0] balance;
    logic [2:0] bright;
  } keyCfgT;

  typedef enum logic [2:0] {
    SH_NONE    = 3'd0,
    SH_FULL    = 3'd1,
    SH_HALF    = 3'd2,
    SH_THIRD   = 3'd3,
    SH_QUARTER = 3'd4
  } shareT;

  // Slot share of one channel for a balance code
  function automatic shareT shareFor(input logic [2:0] bal, input int ch);
    shareT s;
    s = SH_NONE;
    case (bal)
      3'd0: s = (ch == 0) ? SH_FULL : SH_NONE;
      3'd1: s = (ch == 1) ? SH_FULL : SH_NONE;
      3'd2: s = (ch == 2) ? SH_FULL : SH_NONE;
      3'd3: s = (ch == 2) ? SH_NONE : SH_HALF;
      3'd4: s = (ch == 0) ? SH_NONE : SH_HALF;
      3'd5: s = (ch == 1) ? SH_NONE : SH_HALF;
      3'd6: s = SH_THIRD;
      default: s = (ch == 0) ? SH_HALF : SH_QUARTER;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/keyFrameCtl.sv
module keyFrameCtl
  import keyPwmPkg::*;
#(
  parameter int FRAME_TICKS = 64,
  parameter int POS_W       = $clog2(FRAME_TICKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  output logic [POS_W-1:0] pos,
  output frameStrobeT      strobe
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_TICKS - 1);

  logic atLast;

  assign atLast          = (pos == LAST_POS);
  assign strobe.advance  = tick;
  assign strobe.boundary = tick & atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (strobe.advance) begin
      if (atLast) pos <= '0;
      else        pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/keyPwmPath.sv
module keyPwmPath
  import keyPwmPkg::*;
#(
  parameter int FRAME_TICKS = 64,
  parameter int POS_W       = $clog2(FRAME_TICKS),
  parameter int CHANNELS    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  frameStrobeT         strobe,
  input  logic [POS_W-1:0]    pos,
  input  keyCfgT              cfgIn,
  input  logic                extPwm,
  output keyCfgT              cfgQ,
  output logic [CHANNELS-1:0] ledOn
);

  localparam int SUM_W = $clog2(FRAME_TICKS + 1) + 1;
  localparam logic [SUM_W-1:0] FULL_T    = SUM_W'(FRAME_TICKS);
  localparam logic [SUM_W-1:0] HALF_T    = SUM_W'(FRAME_TICKS / 2);
  localparam logic [SUM_W-1:0] THIRD_T   = SUM_W'(FRAME_TICKS / 3);
  localparam logic [SUM_W-1:0] QUARTER_T = SUM_W'(FRAME_TICKS / 4);

  function automatic logic [SUM_W-1:0] shareTicks(input shareT s);
    logic [SUM_W-1:0] t;
    case (s)
      SH_FULL:    t = FULL_T;
      SH_HALF:    t = HALF_T;
      SH_THIRD:   t = THIRD_T;
      SH_QUARTER: t = QUARTER_T;
      default:    t = '0;
    endcase
    return t;
  endfunction

  // Logarithmic brightness: code 0 is dark, code k keeps 2^(k-7) of val
  function automatic logic [SUM_W-1:0] scaleLog(input logic [SUM_W-1:0] val,
                                                input logic [2:0] code);
    logic [SUM_W-1:0] r;
    if (code == 3'd0) r = '0;
    else              r = val >> (3'd7 - code);
    return r;
  endfunction

  // Settings shadow, loaded only on the wrapping tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgQ <= '0;
    else if (strobe.boundary) cfgQ <= cfgIn;
  end

  logic [SUM_W-1:0]    posX;
  logic [SUM_W-1:0]    sharedLen;
  logic [SUM_W-1:0]    slotLen   [CHANNELS];
  logic [SUM_W-1:0]    slotStart [CHANNELS];
  logic [CHANNELS-1:0] intWave;
  logic [CHANNELS-1:0] nextOn;

  assign posX      = SUM_W'(pos);
  assign sharedLen = scaleLog(FULL_T, cfgQ.bright);

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : gChan
    assign slotLen[ch] = scaleLog(shareTicks(shareFor(cfgQ.balance, ch)), cfgQ.bright);

    if (ch == 0) begin : gFirst
      assign slotStart[ch] = '0;
    end else begin : gNext
      assign slotStart[ch] = slotStart[ch-1] + slotLen[ch-1];
    end

    logic inSlot;
    logic baseOn;
    logic routeExt;

    assign inSlot       = (posX >= slotStart[ch]) && (posX < slotStart[ch] + slotLen[ch]);
    assign intWave[ch]  = cfgQ.overlap ? (posX < sharedLen) : inSlot;
    assign baseOn       = cfgQ.chanEn[ch] & (cfgQ.intPwmEn ? intWave[ch] : 1'b1);
    assign routeExt     = cfgQ.pinEn & cfgQ.extSel[ch];
    assign nextOn[ch]   = cfgQ.keyEn & baseOn & (routeExt ? extPwm : 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ledOn <= '0;
    else       ledOn <= nextOn;
  end

endmodule

// File: rtl/keyLedSeq.sv
module keyLedSeq
  import keyPwmPkg::*;
#(
  parameter int FRAME_TICKS = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       keyEn,
  input  logic       intPwmEn,
  input  logic       pinEn,
  input  logic       overlap,
  input  logic [2:0] chanEn,
  input  logic [2:0] extSel,
  input  logic [2:0] balance,
  input  logic [2:0] bright,
  input  logic       extPwm,
  output logic [2:0] ledOn
);

  localparam int POS_W = $clog2(FRAME_TICKS);

  logic [POS_W-1:0] pos;
  frameStrobeT      strobe;
  keyCfgT           cfgIn;
  keyCfgT           cfgQ;

  assign cfgIn = '{keyEn: keyEn, intPwmEn: intPwmEn, pinEn: pinEn, overlap: overlap,
                   chanEn: chanEn, extSel: extSel, balance: balance, bright: bright};

  keyFrameCtl #(.FRAME_TICKS(FRAME_TICKS), .POS_W(POS_W)) uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .pos    (pos),
    .strobe (strobe)
  );

  keyPwmPath #(.FRAME_TICKS(FRAME_TICKS), .POS_W(POS_W), .CHANNELS(3)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pos    (pos),
    .cfgIn  (cfgIn),
    .extPwm (extPwm),
    .cfgQ   (cfgQ),
    .ledOn  (ledOn)
  );

endmodule

// File: rtl/keyLedSeqChk.sv
module keyLedSeqChk
  import keyPwmPkg::*;
#(
  parameter int FRAME_TICKS = 64,
  parameter int POS_W       = $clog2(FRAME_TICKS)
) (
  input logic             clk,
  input logic             rstN,
  input logic [POS_W-1:0] pos,
  input frameStrobeT      strobe,
  input keyCfgT           cfgQ,
  input logic [2:0]       ledOn
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_TICKS - 1);

  // R2: position stays inside the frame
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    pos <= LAST_POS);

  // R2: position moves by one on a tick that is not the last
  assert_pos_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && pos != LAST_POS) |=> pos == $past(pos) + 1'b1);

  // R2: no tick, no movement
  assert_pos_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(pos));

  // R3: captured settings change only at the frame end
  assert_cfg_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.boundary |=> $stable(cfgQ));

  // R4: global disable darkens everything
  assert_global_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.keyEn |=> ledOn == 3'b000);

  // R5: direct mode without pin routing follows the enables
  assert_direct_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.keyEn && !cfgQ.intPwmEn && !cfgQ.pinEn) |=> ledOn == $past(cfgQ.chanEn));

  // R7: shared mode lights all enabled channels together or none
  assert_shared_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.keyEn && cfgQ.intPwmEn && cfgQ.overlap && !cfgQ.pinEn)
      |=> (ledOn == 3'b000 || ledOn == $past(cfgQ.chanEn)));

  // R8: sliced mode never lights two channels at once
  assert_sliced_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ.keyEn && cfgQ.intPwmEn && !cfgQ.overlap) |=> $onehot0(ledOn));

  // R1: reset clears the outputs
  always @(posedge clk) begin
    if (!rstN) assert_reset_off_R1: assert (ledOn == 3'b000);
  end

endmodule

bind keyLedSeq keyLedSeqChk #(.FRAME_TICKS(FRAME_TICKS)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .pos    (pos),
  .strobe (strobe),
  .cfgQ   (cfgQ),
  .ledOn  (ledOn)
);

// File: tb/sim_keyLedSeq.sv
module sim_keyLedSeq;

  localparam int CLK_PERIOD = 10;
  localparam int F          = 64;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       keyEn = 1'b0, intPwmEn = 1'b0, pinEn = 1'b0, overlap = 1'b0;
  logic [2:0] chanEn = '0, extSel = '0, balance = '0, bright = '0;
  logic       extPwm = 1'b0;
  logic [2:0] ledOn;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  bit autoChk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyLedSeq #(.FRAME_TICKS(F)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .keyEn(keyEn), .intPwmEn(intPwmEn),
    .pinEn(pinEn), .overlap(overlap), .chanEn(chanEn), .extSel(extSel),
    .balance(balance), .bright(bright), .extPwm(extPwm), .ledOn(ledOn)
  );

  // ---------------- reference model from the requirements ----------------
  int         mPos;
  bit         mKey, mInt, mPin, mOvl;
  bit [2:0]   mChan, mSel, mBal, mBri;
  bit [2:0]   expLed;

  function automatic int logScale(int full, int code);
    if (code == 0) return 0;
    return full / (1 << (7 - code));
  endfunction

  function automatic int sharePct(int bal, int ch);
    int p[3];
    case (bal)
      0: p = '{100, 0, 0};
      1: p = '{0, 100, 0};
      2: p = '{0, 0, 100};
      3: p = '{50, 50, 0};
      4: p = '{0, 50, 50};
      5: p = '{50, 0, 50};
      6: p = '{33, 33, 33};
      default: p = '{50, 25, 25};
    endcase
    return p[ch];
  endfunction

  function automatic int pctTicks(int pct);
    if (pct == 100) return F;
    if (pct == 50)  return F / 2;
    if (pct == 33)  return F / 3;
    if (pct == 25)  return F / 4;
    return 0;
  endfunction

  function automatic bit [2:0] expectLed(int p, bit k, bit ip, bit pe, bit ov,
                                         bit [2:0] en, bit [2:0] sel, bit [2:0] bal,
                                         bit [2:0] bri, bit ext);
    bit [2:0] r;
    int start;
    start = 0;
    for (int ch = 0; ch < 3; ch++) begin
      int len;
      bit w, o;
      len = logScale(pctTicks(sharePct(bal, ch)), bri);
      if (ov) w = (p < logScale(F, bri));
      else    w = (p >= start) && (p < start + len);
      start += len;
      o = en[ch] && (ip ? w : 1'b1);
      if (pe && sel[ch]) o = o && ext;
      r[ch] = k && o;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPos <= 0; mKey <= 0; mInt <= 0; mPin <= 0; mOvl <= 0;
      mChan <= 0; mSel <= 0; mBal <= 0; mBri <= 0; expLed <= 0;
    end else begin
      expLed <= expectLed(mPos, mKey, mInt, mPin, mOvl, mChan, mSel, mBal, mBri, extPwm);
      if (tick) begin
        if (mPos == F - 1) begin
          mPos <= 0;
          mKey <= keyEn; mInt <= intPwmEn; mPin <= pinEn; mOvl <= overlap;
          mChan <= chanEn; mSel <= extSel; mBal <= balance; mBri <= bright;
        end else begin
          mPos <= mPos + 1;
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ledOn actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic string modeTag();
    if (!mKey)              return "R4";
    if (mPin && (mSel & mChan) != 0) return "R9";
    if (!mPin && mSel != 0) return "R10";
    if (!mInt)              return "R5";
    if (mOvl)               return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (autoChk && rstN && !done) check(modeTag(), ledOn, expLed);
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      finishRun();
    end
  end

  task automatic step(bit t, bit e);
    @(negedge clk);
    tick = t;
    extPwm = e;
  endtask

  task automatic setCfg(bit k, bit ip, bit pe, bit ov, bit [2:0] en, bit [2:0] sel,
                        bit [2:0] bal, bit [2:0] bri);
    keyEn = k; intPwmEn = ip; pinEn = pe; overlap = ov;
    chanEn = en; extSel = sel; balance = bal; bright = bri;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int cnt;
    void'($urandom(32'd20250611));

    // R1: reset state
    setCfg(1, 0, 0, 0, 3'b111, 0, 0, 7);
    repeat (3) step(1, 0);
    check("R1", ledOn, 3'b000);
    @(negedge clk) rstN = 1'b1;
    // R3/R1: settings not yet captured, outputs stay dark for the first frame
    repeat (20) step(1, 0);
    check("R3", ledOn, 3'b000);
    autoChk = 1'b1;
    repeat (F + 5) step(1, 0);
    check("R5", ledOn, 3'b111);

    // R6: on-count per frame in shared mode for every brightness code
    for (int b = 0; b < 8; b++) begin
      setCfg(1, 1, 0, 1, 3'b001, 0, 3'd6, 3'(b));
      repeat (2 * F + 2) step(1, 0);
      cnt = 0;
      for (int i = 0; i < F; i++) begin
        step(1, 0);
        cnt += ledOn[0];
      end
      checks++;
      if (cnt != logScale(F, b)) begin
        errors++;
        $display("FAIL R6 on-count actual=%0d expected=%0d code=%0d", cnt, logScale(F, b), b);
      end
    end

    // R2: tick every other cycle doubles the frame in cycles
    setCfg(1, 1, 0, 1, 3'b010, 0, 0, 3'd4);
    repeat (4 * F + 4) step(cyc % 2, 0);
    cnt = 0;
    for (int i = 0; i < 2 * F; i++) begin
      step(i % 2, 0);
      cnt += ledOn[1];
    end
    checks++;
    if (cnt != 2 * logScale(F, 4)) begin
      errors++;
      $display("FAIL R2 on-count actual=%0d expected=%0d", cnt, 2 * logScale(F, 4));
    end

    // R8: slot counts for balance 7 at full brightness
    setCfg(1, 1, 0, 0, 3'b111, 0, 3'd7, 3'd7);
    repeat (2 * F + 2) step(1, 0);
    begin
      int c0, c1, c2;
      c0 = 0; c1 = 0; c2 = 0;
      for (int i = 0; i < F; i++) begin
        step(1, 0);
        c0 += ledOn[0]; c1 += ledOn[1]; c2 += ledOn[2];
      end
      checks++;
      if (c0 != F / 2 || c1 != F / 4 || c2 != F / 4) begin
        errors++;
        $display("FAIL R8 slot counts actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                 c0, c1, c2, F / 2, F / 4, F / 4);
      end
    end

    // R9: pin held low blocks routed channel in direct mode
    setCfg(1, 0, 1, 0, 3'b111, 3'b100, 0, 0);
    repeat (2 * F + 2) step(1, 0);
    step(1, 0);
    step(1, 0);
    check("R9", ledOn, 3'b011);

    // R10: routing ignored while pin function is off
    setCfg(1, 0, 0, 0, 3'b111, 3'b111, 0, 0);
    repeat (2 * F + 2) step(1, 0);
    check("R10", ledOn, 3'b111);

    // R4: global disable
    setCfg(0, 1, 1, 1, 3'b111, 3'b111, 0, 7);
    repeat (2 * F + 2) step(1, 1);
    check("R4", ledOn, 3'b000);

    // constrained random: settings change anywhere in the frame
    for (int n = 0; n < 160; n++) begin
      int hold;
      setCfg(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
             3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom));
      hold = 30 + ($urandom % 200);
      for (int i = 0; i < hold; i++) begin
        bit t;
        t = (($urandom % 4) != 0);
        step(t, (($urandom % 5) == 0) ? ~extPwm : extPwm);
      end
    end

    autoChk = 1'b0;
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule